// File: doc/BRIEF.md
# Bi-Phase Line Fault Injector

This block sits between a Manchester bi-phase word encoder and the line driver and corrupts the outgoing waveform on command. It follows the encoder's word-boundary strobes and counts 50 ns ticks from the start of each word. In one chosen word of a message it can open a fault window. Inside that window the line is either released to idle or driven with the opposite level. Because the window can land anywhere in the word, including the sync field and the parity bit, the same mechanism can produce malformed sync, wrong parity and bi-phase violations, as well as plain data bit flips.

The block can also change the length of the chosen word. It can cut the last one to three bit cells off the word, or it can append one to three extra bit cells after the word. It can also stretch the dead time before the next word by one to three microseconds. While the block is adding cells or holding the dead time, it raises a hold request so that the encoder waits before it starts the next word. When no fault applies, the encoder's level and enable pass straight through with a latency of one register.

Top module: `mbp_fault_injector`

## Requirements
- R1: When no fault applies, `line_level_o` and `line_drive_o` equal `enc_level_i` and `enc_drive_i` from exactly one clock earlier, and there is no combinational path from input to output.
- R2: With `cfg_kind_i` = 1 (blank), every sample inside the fault window leaves the block with drive 0 and level 0.
- R3: With `cfg_kind_i` = 2 (flip), every sample inside the fault window leaves the block with its level inverted and its drive unchanged. Kind values 0 and 3 open no window.
- R4: The tick on which `word_start_i` is high is tick 0 of the word. The window covers ticks `cfg_off_i`×10 up to, but not including, `cfg_off_i`×10 + width. The window is clipped at the end of the word. A width of 0 opens no window.
- R5: A width above 60 ticks (3 µs) is treated as 60.
- R6: A word that starts together with `msg_start_i` is word 0, and each further `word_start_i` adds one to the word number. Only the word whose number equals `cfg_word_i` is affected, and nothing is affected while `cfg_arm_i` is 0.
- R7: With `cfg_bits_i[2]` = 1 and n = `cfg_bits_i[1:0]` > 0, the last n×20 ticks of the chosen word leave the block idle (drive 0, level 0).
- R8: With `cfg_bits_i[2]` = 0 and n = `cfg_bits_i[1:0]` > 0, n extra bit cells follow the chosen word directly on the line. Each cell is 10 ticks low and then 10 ticks high with drive 1. `enc_hold_o` is high while the cells are being sent.
- R9: With d = `cfg_gap_i` > 0, d×20 ticks of idle line with `enc_hold_o` high follow the chosen word and any extra cells. After that, `enc_hold_o` falls.
- R10: While `rst` is high, all three outputs are 0 and any extra cells or dead time in progress are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | 50 ns time-base strobe |
| enc_level_i | input | 1 | Encoder line level |
| enc_drive_i | input | 1 | Encoder drive enable |
| word_start_i | input | 1 | High on the first sample of a word |
| msg_start_i | input | 1 | High with `word_start_i` on the first word of a message |
| word_end_i | input | 1 | High on the last sample of a word |
| cfg_arm_i | input | 1 | Enables fault injection |
| cfg_word_i | input | 5 | Number of the target word |
| cfg_kind_i | input | 2 | Window fault: 1 blank, 2 flip, other values none |
| cfg_off_i | input | 6 | Window start in 500 ns steps |
| cfg_wid_i | input | 6 | Window width in 50 ns ticks |
| cfg_bits_i | input | 3 | Bit 2 selects removal (1) or addition (0); bits 1:0 give the cell count |
| cfg_gap_i | input | 2 | Extra dead time in µs |
| line_level_o | output | 1 | Level sent to the line |
| line_drive_o | output | 1 | Drive enable sent to the line |
| enc_hold_o | output | 1 | Asks the encoder to wait before the next word |

## Verification
A wrong word-tick count or word number moves the window or truncation to a different place, or into a different word. This shows on the very next cycle as extra or missing inverted or idle samples. Miscounting the window length changes the number of corrupted samples in the word. A tail state that is left stuck or entered too early keeps `enc_hold_o` high, or makes it fall too soon. This shows in the total hold time and in the number of extra driven cells, both measured within one message. Each message is therefore scored by counting each kind of deviation against the expected totals.

// File: rtl/einj_pkg.sv
package einj_pkg;

    typedef enum logic [1:0] {
        FLT_OFF   = 2'd0,
        FLT_BLANK = 2'd1,
        FLT_FLIP  = 2'd2,
        FLT_RSVD  = 2'd3
    } flt_kind_e;

    typedef enum logic [1:0] {
        TL_IDLE  = 2'd0,
        TL_EXTRA = 2'd1,
        TL_DEAD  = 2'd2
    } tail_ph_e;

    typedef struct packed {
        logic level;
        logic drive;
    } line_t;

    localparam line_t LINE_IDLE = '{level: 1'b0, drive: 1'b0};

    function automatic logic kind_opens_window(input flt_kind_e k);
        return (k == FLT_BLANK) || (k == FLT_FLIP);
    endfunction

endpackage

// File: rtl/einj_word_track.sv
module einj_word_track #(
    parameter int CNT_W   = 9,
    parameter int WORD_W  = 5,
    parameter int CNT_MAX = 400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              msg_start_i,
    input  logic              word_start_i,
    input  logic              word_end_i,
    input  logic [WORD_W-1:0] cfg_word_i,
    output logic [CNT_W-1:0]  cnt_now_o,
    output logic              sel_now_o,
    output logic              in_word_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] idx_q, idx_now;
    logic              inw_q;

    always_comb begin
        idx_now   = word_start_i ? (msg_start_i ? '0 : idx_q + 1'b1) : idx_q;
        cnt_now_o = word_start_i ? '0 : cnt_q;
        in_word_o = word_start_i | inw_q;
        sel_now_o = (idx_now == cfg_word_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            idx_q <= '0;
            inw_q <= 1'b0;
        end else begin
            idx_q <= idx_now;
            inw_q <= in_word_o & ~word_end_i;
            if (tick_i && cnt_now_o != CNT_TOP)
                cnt_q <= cnt_now_o + 1'b1;
            else
                cnt_q <= cnt_now_o;
        end
    end

    // R4
    tick_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (word_start_i && tick_i) |=> (cnt_now_o <= CNT_W'(1)) || word_start_i);

endmodule

// File: rtl/einj_window.sv
module einj_window
    import einj_pkg::*;
#(
    parameter int CNT_W = 9,
    parameter int OFF_W = 6,
    parameter int WID_W = 6,
    parameter int STEP  = 10,
    parameter int MAXW  = 60,
    parameter int TPB   = 20,
    parameter int BITS  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_now_i,
    input  logic             sel_now_i,
    input  logic             in_word_i,
    input  logic             arm_i,
    input  flt_kind_e        kind_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [WID_W-1:0] wid_i,
    input  logic [2:0]       bits_i,
    output logic             win_o,
    output logic             cut_o
);
    localparam int SW = CNT_W + OFF_W + 8;
    localparam logic [WID_W-1:0] WID_CAP = WID_W'(MAXW);

    logic [SW-1:0] cnt_w, start_w, stop_w, wid_w, cut_from;
    logic          hit;
    logic [CNT_W-1:0] run_q;

    always_comb begin
        hit      = arm_i & sel_now_i & in_word_i;
        cnt_w    = SW'(cnt_now_i);
        wid_w    = (wid_i > WID_CAP) ? SW'(WID_CAP) : SW'(wid_i);
        start_w  = SW'(off_i) * SW'(STEP);
        stop_w   = start_w + wid_w;
        cut_from = SW'(BITS * TPB) - SW'(bits_i[1:0]) * SW'(TPB);
        win_o    = hit & kind_opens_window(kind_i) &
                   (cnt_w >= start_w) & (cnt_w < stop_w);
        cut_o    = hit & bits_i[2] & (bits_i[1:0] != 2'd0) & (cnt_w >= cut_from);
    end

    // checker: consecutive window ticks inside one word
    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (!win_o)
            run_q <= '0;
        else
            run_q <= ((cnt_now_i == '0) ? '0 : run_q) + CNT_W'(tick_i);
    end

    // R5
    win_len_chk: assert property (@(posedge clk) disable iff (rst)
        (win_o && cnt_now_i != '0) |-> (run_q < CNT_W'(MAXW)));

endmodule

// File: rtl/einj_tail.sv
module einj_tail
    import einj_pkg::*;
#(
    parameter int TPB = 20
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_i,
    input  logic     fire_i,
    input  logic [1:0] add_i,
    input  logic [1:0] gap_i,
    output tail_ph_e ph_o,
    output logic     cell_hi_o
);
    localparam int TL_W = $clog2(3 * TPB + 1);
    localparam int CW   = (TPB > 2) ? $clog2(TPB) : 1;
    localparam logic [CW-1:0] CELL_LAST = CW'(TPB - 1);
    localparam logic [CW-1:0] CELL_HALF = CW'(TPB / 2);

    tail_ph_e        ph_q;
    logic [TL_W-1:0] pcnt_q, extra_len, dead_len;
    logic [CW-1:0]   cell_q;
    logic [1:0]      add_q, gap_q;

    assign extra_len = TL_W'(add_q) * TL_W'(TPB);
    assign dead_len  = TL_W'(gap_q) * TL_W'(TPB);
    assign ph_o      = ph_q;
    assign cell_hi_o = (cell_q >= CELL_HALF);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= TL_IDLE;
            pcnt_q <= '0;
            cell_q <= '0;
            add_q  <= '0;
            gap_q  <= '0;
        end else begin
            case (ph_q)
                TL_IDLE: begin
                    pcnt_q <= '0;
                    cell_q <= '0;
                    if (fire_i) begin
                        add_q <= add_i;
                        gap_q <= gap_i;
                        if (add_i != 2'd0)      ph_q <= TL_EXTRA;
                        else if (gap_i != 2'd0) ph_q <= TL_DEAD;
                    end
                end
                TL_EXTRA: if (tick_i) begin
                    cell_q <= (cell_q == CELL_LAST) ? '0 : cell_q + 1'b1;
                    if (pcnt_q == extra_len - 1'b1) begin
                        pcnt_q <= '0;
                        ph_q   <= (gap_q != 2'd0) ? TL_DEAD : TL_IDLE;
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
                TL_DEAD: if (tick_i) begin
                    if (pcnt_q == dead_len - 1'b1) begin
                        pcnt_q <= '0;
                        ph_q   <= TL_IDLE;
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
                default: ph_q <= TL_IDLE;
            endcase
        end
    end

    // R9
    dead_span_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == TL_DEAD) |-> (gap_q != 2'd0) && (pcnt_q < dead_len));

    // R8
    extra_span_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == TL_EXTRA) |-> (add_q != 2'd0) && (pcnt_q < extra_len));

endmodule

// File: rtl/mbp_fault_injector.sv
module mbp_fault_injector
    import einj_pkg::*;
#(
    parameter int WORD_W = 5,
    parameter int OFF_W  = 6,
    parameter int WID_W  = 6,
    parameter int TPB    = 20,
    parameter int BITS   = 20,
    parameter int STEP   = 10,
    parameter int MAXW   = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              enc_level_i,
    input  logic              enc_drive_i,
    input  logic              word_start_i,
    input  logic              msg_start_i,
    input  logic              word_end_i,
    input  logic              cfg_arm_i,
    input  logic [WORD_W-1:0] cfg_word_i,
    input  logic [1:0]        cfg_kind_i,
    input  logic [OFF_W-1:0]  cfg_off_i,
    input  logic [WID_W-1:0]  cfg_wid_i,
    input  logic [2:0]        cfg_bits_i,
    input  logic [1:0]        cfg_gap_i,
    output logic              line_level_o,
    output logic              line_drive_o,
    output logic              enc_hold_o
);
    localparam int WORD_TICKS = BITS * TPB;
    localparam int CNT_W      = $clog2(WORD_TICKS + 1);

    flt_kind_e        kind;
    logic [CNT_W-1:0] cnt_now;
    logic             sel_now, in_word, win, cut, fire, cell_hi;
    logic [1:0]       add_n;
    tail_ph_e         ph;
    line_t            enc_s, nxt, out_q;

    assign kind  = flt_kind_e'(cfg_kind_i);
    assign enc_s = '{level: enc_level_i, drive: enc_drive_i};
    assign add_n = cfg_bits_i[2] ? 2'd0 : cfg_bits_i[1:0];
    assign fire  = word_end_i & in_word & sel_now & cfg_arm_i & (ph == TL_IDLE);

    einj_word_track #(.CNT_W(CNT_W), .WORD_W(WORD_W), .CNT_MAX(WORD_TICKS)) u_track (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .msg_start_i(msg_start_i), .word_start_i(word_start_i), .word_end_i(word_end_i),
        .cfg_word_i(cfg_word_i),
        .cnt_now_o(cnt_now), .sel_now_o(sel_now), .in_word_o(in_word)
    );

    einj_window #(.CNT_W(CNT_W), .OFF_W(OFF_W), .WID_W(WID_W), .STEP(STEP),
                  .MAXW(MAXW), .TPB(TPB), .BITS(BITS)) u_window (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .cnt_now_i(cnt_now), .sel_now_i(sel_now), .in_word_i(in_word),
        .arm_i(cfg_arm_i), .kind_i(kind), .off_i(cfg_off_i), .wid_i(cfg_wid_i),
        .bits_i(cfg_bits_i), .win_o(win), .cut_o(cut)
    );

    einj_tail #(.TPB(TPB)) u_tail (
        .clk(clk), .rst(rst), .tick_i(tick_i), .fire_i(fire),
        .add_i(add_n), .gap_i(cfg_gap_i), .ph_o(ph), .cell_hi_o(cell_hi)
    );

    always_comb begin
        nxt = enc_s;
        if (ph == TL_EXTRA)
            nxt = '{level: cell_hi, drive: 1'b1};
        else if (ph == TL_DEAD)
            nxt = LINE_IDLE;
        else if (cut || (win && kind == FLT_BLANK))
            nxt = LINE_IDLE;
        else if (win && kind == FLT_FLIP)
            nxt = '{level: ~enc_level_i, drive: enc_drive_i};
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= LINE_IDLE;
        else     out_q <= nxt;
    end

    assign line_level_o = out_q.level;
    assign line_drive_o = out_q.drive;
    assign enc_hold_o   = (ph != TL_IDLE);

    // R1
    pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
        (!win && !cut && ph == TL_IDLE) |=>
            (line_level_o == $past(enc_level_i)) && (line_drive_o == $past(enc_drive_i)));

    // R2
    blank_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (win && kind == FLT_BLANK && ph == TL_IDLE) |=> (!line_drive_o && !line_level_o));

    // R3
    flip_level_chk: assert property (@(posedge clk) disable iff (rst)
        (win && kind == FLT_FLIP && !cut && ph == TL_IDLE) |=>
            (line_level_o != $past(enc_level_i)) && (line_drive_o == $past(enc_drive_i)));

    // R8
    extra_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == TL_EXTRA) |=> line_drive_o);

    // R7
    cut_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cut && ph == TL_IDLE) |=> !line_drive_o);

endmodule

// File: tb/test_mbp_fault_injector.sv
module test_mbp_fault_injector;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_i = 1'b1;
    logic enc_level_i = 1'b0, enc_drive_i = 1'b0;
    logic word_start_i = 1'b0, msg_start_i = 1'b0, word_end_i = 1'b0;
    logic cfg_arm_i = 1'b0;
    logic [4:0] cfg_word_i = '0;
    logic [1:0] cfg_kind_i = '0;
    logic [5:0] cfg_off_i = '0, cfg_wid_i = '0;
    logic [2:0] cfg_bits_i = '0;
    logic [1:0] cfg_gap_i = '0;
    logic line_level_o, line_drive_o, enc_hold_o;

    always #4 clk = ~clk;

    mbp_fault_injector i_mbp_fault_injector (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .enc_level_i(enc_level_i), .enc_drive_i(enc_drive_i),
        .word_start_i(word_start_i), .msg_start_i(msg_start_i), .word_end_i(word_end_i),
        .cfg_arm_i(cfg_arm_i), .cfg_word_i(cfg_word_i), .cfg_kind_i(cfg_kind_i),
        .cfg_off_i(cfg_off_i), .cfg_wid_i(cfg_wid_i), .cfg_bits_i(cfg_bits_i),
        .cfg_gap_i(cfg_gap_i),
        .line_level_o(line_level_o), .line_drive_o(line_drive_o), .enc_hold_o(enc_hold_o)
    );

    typedef struct packed {
        logic       arm;
        logic [4:0] word;
        logic [1:0] kind;
        logic [5:0] off;
        logic [5:0] wid;
        logic [2:0] bits;
        logic [1:0] gap;
        logic [9:0] e_inv;
        logic [9:0] e_blank;
        logic [9:0] e_extra;
        logic [9:0] e_hi;
        logic [9:0] e_hold;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'd1, 2'd1, 6'd2,  6'd10, 3'b000, 2'd0, 10'd0,  10'd0,  10'd0,  10'd0,  10'd0},
        '{1'b1, 5'd1, 2'd1, 6'd3,  6'd25, 3'b000, 2'd0, 10'd0,  10'd25, 10'd0,  10'd0,  10'd0},
        '{1'b1, 5'd0, 2'd2, 6'd0,  6'd60, 3'b000, 2'd0, 10'd60, 10'd0,  10'd0,  10'd0,  10'd0},
        '{1'b1, 5'd2, 2'd2, 6'd39, 6'd60, 3'b000, 2'd0, 10'd10, 10'd0,  10'd0,  10'd0,  10'd0},
        '{1'b1, 5'd1, 2'd1, 6'd5,  6'd63, 3'b000, 2'd0, 10'd0,  10'd60, 10'd0,  10'd0,  10'd0},
        '{1'b1, 5'd1, 2'd0, 6'd0,  6'd0,  3'b110, 2'd0, 10'd0,  10'd40, 10'd0,  10'd0,  10'd0},
        '{1'b1, 5'd0, 2'd0, 6'd0,  6'd0,  3'b011, 2'd0, 10'd0,  10'd0,  10'd60, 10'd30, 10'd60},
        '{1'b1, 5'd1, 2'd0, 6'd0,  6'd0,  3'b000, 2'd2, 10'd0,  10'd0,  10'd0,  10'd0,  10'd40},
        '{1'b1, 5'd2, 2'd2, 6'd1,  6'd5,  3'b001, 2'd3, 10'd5,  10'd0,  10'd20, 10'd10, 10'd80},
        '{1'b1, 5'd0, 2'd1, 6'd4,  6'd0,  3'b000, 2'd0, 10'd0,  10'd0,  10'd0,  10'd0,  10'd0}
    };

    int n_chk = 0, n_fail = 0;
    int n_inv, n_blank, n_extra, n_hi, n_hold;
    logic prev_lv = 1'b0, prev_dr = 1'b0;

    function automatic string tag_of(input int i);
        case (i)
            0: return "V0 R6 disarmed";
            1: return "V1 R2 R4 blank";
            2: return "V2 R3 flip sync";
            3: return "V3 R3 R4 clip";
            4: return "V4 R5 wide";
            5: return "V5 R7 remove";
            6: return "V6 R8 add";
            7: return "V7 R9 gap";
            8: return "V8 R3 R8 R9 mix";
            default: return "V9 R4 zero";
        endcase
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic observe();
        if (prev_dr && line_drive_o && (line_level_o != prev_lv)) n_inv++;
        if (prev_dr && !line_drive_o) n_blank++;
        if (!prev_dr && line_drive_o) begin
            n_extra++;
            if (line_level_o) n_hi++;
        end
        if (enc_hold_o) n_hold++;
    endtask

    task automatic step(input logic lv, input logic dr, input logic ws,
                        input logic ms, input logic we);
        @(negedge clk);
        observe();
        enc_level_i  = lv;
        enc_drive_i  = dr;
        word_start_i = ws;
        msg_start_i  = ms;
        word_end_i   = we;
        prev_lv      = lv;
        prev_dr      = dr;
    endtask

    function automatic logic pat(input int k);
        return logic'((k / 7) % 2);
    endfunction

    task automatic send_word(input logic first);
        for (int k = 0; k < 400; k++)
            step(pat(k), 1'b1, k == 0, first && (k == 0), k == 399);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        while (enc_hold_o) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired, run did not complete");
        summary();
        $finish;
    end

    initial begin
        // R10: outputs held low in reset even with active encoder inputs
        enc_level_i = 1'b1;
        enc_drive_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 reset line_level_o", int'(line_level_o), 0);
        chk("R10 reset line_drive_o", int'(line_drive_o), 0);
        chk("R10 reset enc_hold_o",   int'(enc_hold_o), 0);
        rst = 1'b0;
        enc_level_i = 1'b0;
        enc_drive_i = 1'b0;
        repeat (2) @(negedge clk);

        // R1: one register of latency, no same-cycle path
        enc_level_i = 1'b1;
        enc_drive_i = 1'b1;
        #1;
        chk("R1 no same-cycle path", int'(line_level_o), 0);
        @(negedge clk);
        chk("R1 level after one cycle", int'(line_level_o), 1);
        chk("R1 drive after one cycle", int'(line_drive_o), 1);
        enc_level_i = 1'b0;
        enc_drive_i = 1'b0;
        @(negedge clk);
        prev_lv = 1'b0;
        prev_dr = 1'b0;

        // table of vectors: three-word message per entry
        for (int i = 0; i < NV; i++) begin
            cfg_arm_i  = VEC[i].arm;
            cfg_word_i = VEC[i].word;
            cfg_kind_i = VEC[i].kind;
            cfg_off_i  = VEC[i].off;
            cfg_wid_i  = VEC[i].wid;
            cfg_bits_i = VEC[i].bits;
            cfg_gap_i  = VEC[i].gap;
            n_inv = 0; n_blank = 0; n_extra = 0; n_hi = 0; n_hold = 0;
            for (int w = 0; w < 3; w++) send_word(w == 0);
            repeat (3) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            chk({tag_of(i), " R3 inverted samples"}, n_inv,   int'(VEC[i].e_inv));
            chk({tag_of(i), " R2 idle samples"},     n_blank, int'(VEC[i].e_blank));
            chk({tag_of(i), " R8 extra samples"},    n_extra, int'(VEC[i].e_extra));
            chk({tag_of(i), " R8 extra high"},       n_hi,    int'(VEC[i].e_hi));
            chk({tag_of(i), " R9 hold cycles"},      n_hold,  int'(VEC[i].e_hold));
        end

        // R10: reset during extra cells drops the tail
        cfg_arm_i  = 1'b1;
        cfg_word_i = 5'd0;
        cfg_kind_i = 2'd0;
        cfg_bits_i = 3'b011;
        cfg_gap_i  = 2'd2;
        for (int k = 0; k < 400; k++)
            step(pat(k), 1'b1, k == 0, k == 0, k == 399);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 hold raised after word", int'(enc_hold_o), 1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 hold dropped by reset",  int'(enc_hold_o), 0);
        chk("R10 drive dropped by reset", int'(line_drive_o), 0);
        rst = 1'b0;
        cfg_arm_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 hold stays low after reset", int'(enc_hold_o), 0);

        summary();
        $finish;
    end

endmodule